// File: doc/BRIEF.md
# Infrared Wake Pattern Matcher

This block stays powered while the rest of the system sleeps. It watches a demodulated infrared line, turns it into run-length samples, and compares those samples with a template held in a small on-chip store. When enough of the template agrees with what arrives, it pulses a wake output and latches a status flag.

The host fills the template through a byte-wide register port. It can also set the number of samples that take part in a comparison and the number of mismatches allowed. It can flush the store, read the entry count, and walk the stored entries through a read port with an auto-advancing index. With the compare bit clear and the receiver on, the block runs in learning mode: it records the received samples into the store, beginning at the first pulse, so that a remote's code can be captured and read back.

A sample is one byte. Bit 7 is set for a pulse (carrier present) and clear for a space. Bits 6:0 hold the length in sample periods. Registers, with 4-bit addresses: 0 control (bit 0 compare mode, bit 1 template write enable, bit 2 receiver enable); 1 status (bit 0 match, write 1 to clear); 2 compare depth; 3 mismatch tolerance; 4 entry count (read-only); 5 template push (write); 6 template read port (read); 7 read index (read-only); 8 flush (write, bit 0).

Top module: `irwake_matcher`

## Requirements
- R1: The pin is active-low (low = carrier). Each emitted sample has bit 7 = 1 for a pulse and 0 for a space, and bits 6:0 equal the number of whole sample periods the level lasted, never zero.
- R2: A level lasting more than 127 periods is emitted as one or more saturated entries of length 0x7F, followed by an entry holding the remainder.
- R3: A write to address 5 appends the byte only while control bit 1 is set. Writes made once the store holds TMPL_DEPTH entries are dropped and leave the stored entries unchanged.
- R4: Writing 1 to bit 0 of address 8 empties the store and zeroes the read index, but only while control bit 0 is 0. Otherwise the write has no effect.
- R5: Address 4 reads the entry count. A read of address 6 returns the entry at the read index (address 7), then advances the index, which wraps to 0 after the last entry.
- R6: With control bits 0 and 1 clear and bit 2 set, received samples are appended to the store. While the store is empty, spaces are skipped, so a learned template starts with a pulse.
- R7: A received sample mismatches a template entry if the polarities differ, or if the lengths differ by more than floor(template length / 8). A comparison starts at a received pulse against entry 0. It is abandoned as soon as the mismatch count exceeds the tolerance, and it matches after depth samples if the count is still within the tolerance.
- R8: Comparison runs only while control bits 0 and 2 are both set, the depth is nonzero, and the depth does not exceed the entry count.
- R9: On a match, wake_pulse is high for exactly one cycle and status bit 0 becomes 1.
- R10: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R11: After reset, control, status, count and read index read 0 and wake_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_n | input | 1 | Demodulated infrared line, low while carrier is present |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of the strobe |
| wake_pulse | output | 1 | One-cycle wake event on a match |

## Verification
The bench builds the block with TMPL_DEPTH = 8 and SAMPLE_DIV = 2. This makes a full store and its dropped writes reachable with ten pushes, and keeps each sample period at two clocks. A 130-period pulse then exercises saturation in a few hundred cycles. With these values the bench sweeps every template position through length errors of -4 to +4 against a five-entry template. It predicts each outcome from the one-eighth rule and the tolerance, and adds polarity, depth-gating and multiple-error cases.

// File: rtl/irwake_pkg.sv
package irwake_pkg;
  typedef logic [7:0] ir_sample_t;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_STATUS = 4'd1;
  localparam logic [3:0] A_DEPTH  = 4'd2;
  localparam logic [3:0] A_TOL    = 4'd3;
  localparam logic [3:0] A_COUNT  = 4'd4;
  localparam logic [3:0] A_PUSH   = 4'd5;
  localparam logic [3:0] A_RDATA  = 4'd6;
  localparam logic [3:0] A_RIDX   = 4'd7;
  localparam logic [3:0] A_FLUSH  = 4'd8;

  localparam logic [6:0] RUN_MAX  = 7'h7F;
endpackage

// File: rtl/irwake_sampler.sv
module irwake_sampler
  import irwake_pkg::*;
#(
  parameter int SAMPLE_DIV = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ir_n,
  output logic       smp_valid,
  output ir_sample_t smp
);
  localparam int DW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [1:0]    sync_q;
  logic [DW-1:0] div_q, div_d;
  logic          lvl_q, lvl_d;
  logic [6:0]    run_q, run_d;
  logic          vld_q, vld_d;
  ir_sample_t    smp_q, smp_d;
  logic          tick, carrier;

  assign carrier = ~sync_q[1];
  assign tick    = (div_q == DW'(SAMPLE_DIV - 1));

  always_comb begin
    div_d = tick ? '0 : div_q + DW'(1);
    lvl_d = lvl_q;
    run_d = run_q;
    vld_d = 1'b0;
    smp_d = smp_q;
    if (!enable) begin
      lvl_d = 1'b0;
      run_d = '0;
    end else if (tick) begin
      if (carrier != lvl_q) begin
        if (run_q != '0) begin
          vld_d = 1'b1;
          smp_d = {lvl_q, run_q};
        end
        lvl_d = carrier;
        run_d = 7'd1;
      end else if (run_q == RUN_MAX) begin
        vld_d = 1'b1;
        smp_d = {lvl_q, run_q};
        run_d = 7'd1;
      end else begin
        run_d = run_q + 7'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      div_q  <= '0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
      vld_q  <= 1'b0;
      smp_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], ir_n};
      div_q  <= div_d;
      lvl_q  <= lvl_d;
      run_q  <= run_d;
      vld_q  <= vld_d;
      smp_q  <= smp_d;
    end
  end

  assign smp_valid = vld_q;
  assign smp       = smp_q;

  // R1: an emitted sample never carries a zero length
  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp[6:0] != 7'd0));
  // R2: a saturated run restarts counting at one period
  p_sat_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && run_q == RUN_MAX && carrier == lvl_q) |=> (run_q == 7'd1));
endmodule

// File: rtl/irwake_tmpl_store.sv
module irwake_tmpl_store
  import irwake_pkg::*;
#(
  parameter int DEPTH = 67,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  ir_sample_t    push_data,
  input  logic          clear,
  input  logic          pop,
  input  logic [CW-1:0] cmp_idx,
  output ir_sample_t    cmp_entry,
  output ir_sample_t    rd_entry,
  output logic [CW-1:0] count,
  output logic [CW-1:0] rd_idx
);
  ir_sample_t    mem_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, ridx_q, ridx_d;
  logic          full, wr_en;

  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_en = push && !full;

  always_comb begin
    cnt_d  = cnt_q;
    ridx_d = ridx_q;
    if (clear) begin
      cnt_d  = '0;
      ridx_d = '0;
    end else begin
      if (wr_en) cnt_d = cnt_q + CW'(1);
      if (pop && cnt_q != '0)
        ridx_d = (ridx_q + CW'(1) == cnt_q) ? '0 : ridx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ridx_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ridx_q <= ridx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[cnt_q[AW-1:0]] <= push_data;
  end

  assign cmp_entry = mem_q[cmp_idx[AW-1:0]];
  assign rd_entry  = (cnt_q == '0) ? '0 : mem_q[ridx_q[AW-1:0]];
  assign count     = cnt_q;
  assign rd_idx    = ridx_q;

  // R3: the store never holds more than its depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3: a push into a full store leaves the count alone
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clear) |=> $stable(cnt_q));
  // R5: the read index stays inside the stored entries
  p_ridx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (ridx_q < cnt_q));
endmodule

// File: rtl/irwake_compare.sv
module irwake_compare
  import irwake_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          smp_valid,
  input  ir_sample_t    smp,
  input  logic [7:0]    depth,
  input  logic [7:0]    tol,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cmp_idx,
  input  ir_sample_t    tmpl_entry,
  output logic          hit
);
  logic          act_q, act_d, hit_q, hit_d;
  logic [CW-1:0] idx_q, idx_d, cur_idx;
  logic [7:0]    mis_q, mis_d, cur_mis;
  logic [8:0]    new_mis;
  logic [6:0]    t_len, d_len, diff;
  logic          armed, bad, take;

  assign armed   = enable && (depth != 8'd0) && (depth <= 8'(count));
  assign cur_idx = act_q ? idx_q : '0;
  assign cur_mis = act_q ? mis_q : '0;
  assign t_len   = tmpl_entry[6:0];
  assign d_len   = smp[6:0];
  assign diff    = (d_len >= t_len) ? d_len - t_len : t_len - d_len;
  assign bad     = (smp[7] != tmpl_entry[7]) || (diff > (t_len >> 3));
  assign new_mis = {1'b0, cur_mis} + {8'd0, bad};
  assign take    = smp_valid && armed && (act_q || smp[7]);

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    mis_d = mis_q;
    hit_d = 1'b0;
    if (!armed) begin
      act_d = 1'b0;
    end else if (take) begin
      if (new_mis > {1'b0, tol}) begin
        act_d = 1'b0;
      end else if (8'(cur_idx) == depth - 8'd1) begin
        hit_d = 1'b1;
        act_d = 1'b0;
      end else begin
        act_d = 1'b1;
        idx_d = cur_idx + CW'(1);
        mis_d = new_mis[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      mis_q <= '0;
      hit_q <= 1'b0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      mis_q <= mis_d;
      hit_q <= hit_d;
    end
  end

  assign cmp_idx = cur_idx;
  assign hit     = hit_q;

  // R7: a comparison in flight never carries more mismatches than allowed
  p_mis_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (mis_q <= tol));
  // R8: a hit always follows an armed, accepted sample
  p_hit_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(smp_valid && armed));
  // R9: hits are single-cycle
  p_hit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/irwake_matcher.sv
module irwake_matcher
  import irwake_pkg::*;
#(
  parameter int TMPL_DEPTH = 67,
  parameter int SAMPLE_DIV = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wake_pulse
);
  localparam int CW = $clog2(TMPL_DEPTH + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic [2:0]    ctrl_q, ctrl_d;
  logic [7:0]    depth_q, depth_d, tol_q, tol_d;
  logic          stat_q, stat_d;
  logic          smp_vld, host_push, learn_push, push, flush, pop;
  ir_sample_t    smp, push_data, cmp_entry, rd_entry;
  logic [CW-1:0] count, rd_idx, cmp_idx;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  irwake_sampler #(.SAMPLE_DIV(SAMPLE_DIV)) u_sampler (
    .clk(clk), .rst_n(rst_s_n), .enable(ctrl_q[2]), .ir_n(ir_n),
    .smp_valid(smp_vld), .smp(smp)
  );

  assign host_push  = reg_wr && (reg_addr == A_PUSH) && ctrl_q[1];
  assign learn_push = smp_vld && ctrl_q[2] && !ctrl_q[1] && !ctrl_q[0] &&
                      ((count != '0) || smp[7]);
  assign push       = host_push || learn_push;
  assign push_data  = host_push ? reg_wdata : smp;
  assign flush      = reg_wr && (reg_addr == A_FLUSH) && reg_wdata[0] && !ctrl_q[0];
  assign pop        = reg_rd && (reg_addr == A_RDATA);

  irwake_tmpl_store #(.DEPTH(TMPL_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_s_n), .push(push), .push_data(push_data),
    .clear(flush), .pop(pop), .cmp_idx(cmp_idx), .cmp_entry(cmp_entry),
    .rd_entry(rd_entry), .count(count), .rd_idx(rd_idx)
  );

  irwake_compare #(.CW(CW)) u_compare (
    .clk(clk), .rst_n(rst_s_n), .enable(ctrl_q[2] && ctrl_q[0]),
    .smp_valid(smp_vld), .smp(smp), .depth(depth_q), .tol(tol_q),
    .count(count), .cmp_idx(cmp_idx), .tmpl_entry(cmp_entry), .hit(hit)
  );

  always_comb begin
    ctrl_d  = ctrl_q;
    depth_d = depth_q;
    tol_d   = tol_q;
    stat_d  = stat_q;
    if (reg_wr) begin
      case (reg_addr)
        A_CTRL:   ctrl_d  = reg_wdata[2:0];
        A_DEPTH:  depth_d = reg_wdata;
        A_TOL:    tol_d   = reg_wdata;
        A_STATUS: if (reg_wdata[0]) stat_d = 1'b0;
        default:  ;
      endcase
    end
    if (hit) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q  <= '0;
      depth_q <= '0;
      tol_q   <= '0;
      stat_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      depth_q <= depth_d;
      tol_q   <= tol_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = {5'd0, ctrl_q};
      A_STATUS: reg_rdata = {7'd0, stat_q};
      A_DEPTH:  reg_rdata = depth_q;
      A_TOL:    reg_rdata = tol_q;
      A_COUNT:  reg_rdata = 8'(count);
      A_RDATA:  reg_rdata = rd_entry;
      A_RIDX:   reg_rdata = 8'(rd_idx);
      default:  reg_rdata = 8'd0;
    endcase
  end

  assign wake_pulse = hit;

  // R9: a wake event leaves the status flag set
  p_wake_status_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    wake_pulse |=> stat_q);
  // R4: a flush request in compare mode leaves the count alone
  p_flush_blocked_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr && reg_addr == A_FLUSH && ctrl_q[0]) |=> $stable(count));
  // R10: status only falls after a clearing write
  p_status_w1c_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(stat_q) |-> $past(reg_wr && reg_addr == A_STATUS && reg_wdata[0]));
endmodule

// File: tb/test_irwake_matcher.sv
module test_irwake_matcher;
  localparam int DEP = 8;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_n = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       wake_pulse;

  int checks = 0, errors = 0, wake_cnt = 0;
  bit done = 1'b0;
  int tmpl [5] = '{20, 10, 16, 8, 24};

  irwake_matcher #(.TMPL_DEPTH(DEP), .SAMPLE_DIV(DIV)) i_irwake_matcher (
    .clk(clk), .rst_n(rst_n), .ir_n(ir_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_pulse(wake_pulse)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && wake_pulse === 1'b1) wake_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic seg(bit carrier, int n);
    ir_n = ~carrier;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic load_tmpl(int flip_idx);
    wr(4'd0, 8'h00);
    wr(4'd8, 8'h01);
    wr(4'd0, 8'h02);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] v;
      v = 8'(tmpl[i]);
      if (i % 2 == 0) v[7] = 1'b1;
      if (i == flip_idx) v[7] = ~v[7];
      wr(4'd5, v);
    end
    wr(4'd0, 8'h00);
  endtask

  task automatic run_match(string req, int d [5], int depth, int tol, int exp_wakes);
    logic [7:0] st;
    wr(4'd2, 8'(depth));
    wr(4'd3, 8'(tol));
    wr(4'd1, 8'hFF);
    wake_cnt = 0;
    wr(4'd0, 8'h05);
    seg(1'b0, 6);
    for (int i = 0; i < 5; i++) seg(i % 2 == 0, d[i]);
    seg(1'b0, 6);
    wr(4'd0, 8'h01);
    repeat (4) @(negedge clk);
    check({req, " wake count"}, wake_cnt, exp_wakes);
    rd(4'd1, st);
    check({req, " status"}, st, (exp_wakes != 0) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int d [5];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    rd(4'd0, v); check("R11 ctrl", v, 0);
    rd(4'd1, v); check("R11 status", v, 0);
    rd(4'd4, v); check("R11 count", v, 0);
    rd(4'd7, v); check("R11 ridx", v, 0);
    check("R11 wake", wake_pulse, 0);

    // R3: push gated by write enable, then overflow dropped
    wr(4'd5, 8'h85);
    rd(4'd4, v); check("R3 push while disabled", v, 0);
    wr(4'd0, 8'h02);
    for (int i = 0; i < 10; i++) wr(4'd5, 8'(i * 17 + 3));
    rd(4'd4, v); check("R3 count saturates at depth", v, DEP);
    // R5: read back with advancing index and wrap
    for (int i = 0; i < DEP; i++) begin
      rd(4'd6, v); check("R5 readback entry", v, 8'(i * 17 + 3));
      if (i == 2) begin rd(4'd7, v); check("R5 index advance", v, 3); end
    end
    rd(4'd7, v); check("R5 index wraps", v, 0);

    // R4: flush blocked in compare mode, effective in learning mode
    wr(4'd0, 8'h01);
    wr(4'd8, 8'h01);
    rd(4'd4, v); check("R4 flush blocked", v, DEP);
    wr(4'd0, 8'h00);
    wr(4'd8, 8'h01);
    rd(4'd4, v); check("R4 flush applied", v, 0);

    // R6 R1 R2: learning a pattern with a saturated pulse
    wr(4'd0, 8'h04);
    seg(1'b0, 10);
    seg(1'b1, 130);
    seg(1'b0, 5);
    seg(1'b1, 4);
    seg(1'b0, 3);
    wr(4'd0, 8'h00);
    rd(4'd4, v); check("R6 learned count", v, 4);
    rd(4'd6, v); check("R2 saturated pulse", v, 8'hFF);
    rd(4'd6, v); check("R2 remainder pulse", v, 8'h83);
    rd(4'd6, v); check("R1 space sample", v, 8'h05);
    rd(4'd6, v); check("R1 pulse sample", v, 8'h84);

    // R7: single-position length error sweep, tolerance 0
    load_tmpl(-1);
    rd(4'd4, v); check("R3 template count", v, 5);
    for (int k = 0; k < 5; k++) begin
      for (int e = -4; e <= 4; e++) begin
        int lim, ad;
        d = tmpl;
        d[k] = tmpl[k] + e;
        lim = tmpl[k] / 8;
        ad = (e < 0) ? -e : e;
        run_match("R7 sweep", d, 5, 0, (ad > lim) ? 0 : 1);
      end
    end

    // R7: two errors against tolerances 0..2
    for (int t = 0; t < 3; t++) begin
      d = tmpl;
      d[0] = tmpl[0] + 3;
      d[4] = tmpl[4] + 4;
      run_match("R7 two errors", d, 5, t, (2 <= t) ? 1 : 0);
    end

    // R7: polarity mismatch on entry 2
    load_tmpl(2);
    run_match("R7 polarity tol0", tmpl, 5, 0, 0);
    run_match("R7 polarity tol1", tmpl, 5, 1, 1);

    // R8: depth gating; R9 single event for short depths
    load_tmpl(-1);
    run_match("R8 depth above count", tmpl, 6, 5, 0);
    run_match("R8 depth zero", tmpl, 0, 5, 0);
    run_match("R9 depth three", tmpl, 3, 0, 1);
    run_match("R9 depth one", tmpl, 1, 0, 1);

    // R8: receiver on but compare bit clear gives no wake
    wr(4'd0, 8'h02);
    wr(4'd2, 8'd5);
    wake_cnt = 0;
    wr(4'd0, 8'h06);
    for (int i = 0; i < 5; i++) seg(i % 2 == 0, tmpl[i]);
    seg(1'b0, 6);
    wr(4'd0, 8'h00);
    check("R8 compare bit clear", wake_cnt, 0);

    // R10: status write-one-to-clear
    run_match("R9 set before clear", tmpl, 5, 0, 1);
    wr(4'd1, 8'h00);
    rd(4'd1, v); check("R10 write zero keeps", v, 1);
    wr(4'd1, 8'h01);
    rd(4'd1, v); check("R10 write one clears", v, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule